// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Command Interface

This block holds the main address-translation table of a processor's memory unit. Entries live in `SETS` sets of `WAYS` ways; software reaches them only through four registers: two descriptor words that hold one entry in flight, a slot-index register, and a control register into which a command code is written. The commands search the table, choose a slot for a new entry, commit the descriptors into a slot (with or without invalidating the small per-pipeline translation caches), copy a slot back out, or invalidate those small caches on their own.

Register writes arrive on a valid/ready port. The block drops `cfg_ready` for the single cycle in which a command executes. A source that sees `cfg_ready` low must hold `cfg_valid`, `cfg_addr` and `cfg_wdata` steady until a rising edge at which `cfg_ready` is high, and that edge accepts the write. Register reads are combinational through `rd_addr`/`rd_data`. A separate lookup port lets the small translation caches refill: a request in one cycle returns hit, frame and permissions in the next. The lookup port has no back-pressure and accepts a request in every cycle.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every slot is invalid. Both descriptor registers, the index register and the status register read zero, and `cfg_ready` is high.
- R2: Register map (`rd_addr`/`cfg_addr`): 0 = descriptor A, 1 = descriptor B, 2 = index, 3 = control on write and status on read (bit 0 = busy). Descriptor A holds the virtual page in [31:13], the global flag in bit 9, the present flag in bit 8 and the address-space ID in [7:0]. Descriptor B holds the physical frame in [31:13] and the permissions in [5:0]: kernel read, write, execute in bits 5..3 and user read, write, execute in bits 2..0. Descriptors read back exactly as written. A Read command returns the other bits as zero.
- R3: A control write is accepted when `cfg_valid` and `cfg_ready` are both high. During the next cycle busy reads 1 and `cfg_ready` is low, and the command completes at the end of that cycle. A write offered while busy is held off and then accepted.
- R4: The linear slot index is set × WAYS + way. The set is taken from the low log2(SETS) bits of the virtual page.
- R5: Probe (code 4) compares descriptor A's page and ID with every way of its set. A single match loads the index register with that slot's linear index and clears both error bits.
- R6: A Probe with no match loads the index register with 0x8000_0000. A Probe with two or more matches loads it with 0xC000_0000. Bit 31 therefore flags any error, and bit 30 flags a duplicate.
- R7: A slot matches only when its present flag is set, its page is equal, and either its global flag is set or its ID is equal.
- R8: Pick-slot (code 5) loads the index register with the lowest-numbered empty way of descriptor A's set. When every way is full, it uses that set's rotating pointer and advances the pointer modulo WAYS. Picks that find an empty way leave the pointer unchanged.
- R9: Write (code 1) and Write-keep (code 2) store both descriptors into the slot in index bits [log2(SETS·WAYS)-1:0]. Read (code 3) copies that slot into the descriptors. When index bit 31 is set, all three commands do nothing.
- R10: `utlb_inv` pulses high for one cycle after a performed Write and after Invalidate-micro (code 6). Write-keep and every other command leave it low.
- R11: A lookup request returns `lk_rsp_valid` one cycle later, together with hit and the frame and permissions of the lowest matching way (zeros on a miss). It sees the table as it was before any command completing in the same cycle.
- R12: Writing zero descriptors into a slot erases it, so that slot no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Register write offered |
| cfg_ready | output | 1 | Register write can be taken |
| cfg_addr | input | 2 | Register selected for the write |
| cfg_wdata | input | 32 | Write data or command code in [2:0] |
| rd_addr | input | 2 | Register selected for read |
| rd_data | output | 32 | Read data |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 19 | Lookup virtual page |
| lk_asid | input | 8 | Lookup address-space ID |
| lk_rsp_valid | output | 1 | Lookup response present |
| lk_hit | output | 1 | Lookup found a slot |
| lk_pfn | output | 19 | Physical frame of the hit |
| lk_perm | output | 6 | Permissions of the hit |
| utlb_inv | output | 1 | Invalidate the small translation caches |

## Verification
The bench builds a duplicate pair in one set and expects the distinct duplicate code from Probe, plus the lower way's frame on the lookup port. A design that stopped at the first hit would report a plain index and hide the corrupted set. It fills a set completely and steps the pick-slot pointer through a wrap, and it also empties one way in the middle. A design that rotated even when a free way existed, or that reused the pointer without advancing it, would evict live entries. Writes and reads with the error bit set in the index register must change nothing, and Write-keep must leave the invalidate pulse low. A design that got these wrong would overwrite slot 0 or flush the small caches for nothing.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int REG_W      = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int ASID_W     = 8;
  localparam int PERM_W     = 6;
  localparam int VPN_W      = REG_W - PAGE_SHIFT;
  localparam int PFN_W      = REG_W - PAGE_SHIFT;
  localparam int B_PRESENT  = ASID_W;
  localparam int B_GLOBAL   = ASID_W + 1;
  localparam int B_ERR_ANY  = REG_W - 1;
  localparam int B_ERR_DUP  = REG_W - 2;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;

  typedef enum logic [2:0] {
    CMD_NOP        = 3'd0,
    CMD_WRITE      = 3'd1,
    CMD_WRITE_KEEP = 3'd2,
    CMD_READ       = 3'd3,
    CMD_PROBE      = 3'd4,
    CMD_PICK       = 3'd5,
    CMD_UTLB_INV   = 3'd6,
    CMD_SPARE      = 3'd7
  } tlb_cmd_e;

  typedef enum logic [1:0] {
    RA_DESC_A = 2'd0,
    RA_DESC_B = 2'd1,
    RA_INDEX  = 2'd2,
    RA_CTRL   = 2'd3
  } tlb_reg_e;

  function automatic tlb_ent_t desc_unpack(input logic [REG_W-1:0] wa,
                                           input logic [REG_W-1:0] wb);
    tlb_ent_t e;
    e.valid = wa[B_PRESENT];
    e.glob  = wa[B_GLOBAL];
    e.asid  = wa[ASID_W-1:0];
    e.vpn   = wa[REG_W-1:PAGE_SHIFT];
    e.pfn   = wb[REG_W-1:PAGE_SHIFT];
    e.perm  = wb[PERM_W-1:0];
    return e;
  endfunction

  function automatic logic [REG_W-1:0] desc_a_pack(input tlb_ent_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1:PAGE_SHIFT] = e.vpn;
    w[B_GLOBAL]           = e.glob;
    w[B_PRESENT]          = e.valid;
    w[ASID_W-1:0]         = e.asid;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] desc_b_pack(input tlb_ent_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[REG_W-1:PAGE_SHIFT] = e.pfn;
    w[PERM_W-1:0]         = e.perm;
    return w;
  endfunction
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match
  import tlb_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  tlb_ent_t [WAYS-1:0] ents_i,
  input  logic [VPN_W-1:0]    vpn_i,
  input  logic [ASID_W-1:0]   asid_i,
  output logic [WAYS-1:0]     hit_o,
  output logic [WAY_W-1:0]    first_o
);
  // one comparator per way; R7 matching rule
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_o[w] = ents_i[w].valid && (ents_i[w].vpn == vpn_i) &&
                      (ents_i[w].glob || (ents_i[w].asid == asid_i));
  end

  // lowest matching way wins
  always_comb begin
    first_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_o[w]) first_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] way_o,
  output logic             use_rr_o
);
  always_comb begin
    way_o    = rr_i;
    use_rr_o = 1'b1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        way_o    = WAY_W'(w);
        use_rr_o = 1'b0;
      end
    end
  end

  // R8: an empty way is always preferred over the rotating pointer
  always_comb begin
    if (!$isunknown(valid_i) && !(&valid_i)) begin
      p_prefer_free_r8: assert (!valid_i[way_o] && !use_rr_o);
    end
  end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import tlb_pkg::*;
#(
  parameter int SETS = 128,
  parameter int WAYS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic [1:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_rsp_valid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              utlb_inv
);
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int ENTRIES = SETS * WAYS;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam logic [REG_W-1:0] IDX_KEEP =
    ((REG_W'(1) << IDX_W) - REG_W'(1)) | (REG_W'(3) << (REG_W - 2));
  localparam logic [REG_W-1:0] CODE_MISS = REG_W'(1) << B_ERR_ANY;
  localparam logic [REG_W-1:0] CODE_DUP  = CODE_MISS | (REG_W'(1) << B_ERR_DUP);

  tlb_ent_t         mem_q [ENTRIES];
  logic [WAY_W-1:0] rr_q  [SETS];
  logic [REG_W-1:0] desc_a_q, desc_b_q, idx_q;
  logic             busy_q;
  tlb_cmd_e         cmd_q;

  // set views for command path and lookup path
  logic [SET_W-1:0]   cmd_set, lk_set;
  tlb_ent_t [WAYS-1:0] cmd_ents, lk_ents;
  logic [WAYS-1:0]    cmd_hit, lk_hitv, cmd_valid;
  logic [WAY_W-1:0]   cmd_first, lk_first, vic_way;
  logic               vic_use_rr;
  logic [IDX_W-1:0]   idx_lin;
  logic               idx_err;

  assign cmd_set = desc_a_q[PAGE_SHIFT +: SET_W];
  assign lk_set  = lk_vpn[SET_W-1:0];
  assign idx_lin = idx_q[IDX_W-1:0];
  assign idx_err = idx_q[B_ERR_ANY];

  for (genvar w = 0; w < WAYS; w++) begin : g_view
    assign cmd_ents[w]  = mem_q[{cmd_set, WAY_W'(w)}];
    assign lk_ents[w]   = mem_q[{lk_set, WAY_W'(w)}];
    assign cmd_valid[w] = cmd_ents[w].valid;
  end

  tlb_set_match #(.WAYS(WAYS)) u_cmd_match (
    .ents_i (cmd_ents),
    .vpn_i  (desc_a_q[REG_W-1:PAGE_SHIFT]),
    .asid_i (desc_a_q[ASID_W-1:0]),
    .hit_o  (cmd_hit),
    .first_o(cmd_first)
  );

  tlb_set_match #(.WAYS(WAYS)) u_lk_match (
    .ents_i (lk_ents),
    .vpn_i  (lk_vpn),
    .asid_i (lk_asid),
    .hit_o  (lk_hitv),
    .first_o(lk_first)
  );

  tlb_victim_pick #(.WAYS(WAYS)) u_victim (
    .valid_i (cmd_valid),
    .rr_i    (rr_q[cmd_set]),
    .way_o   (vic_way),
    .use_rr_o(vic_use_rr)
  );

  assign cfg_ready = !busy_q;

  always_comb begin
    case (tlb_reg_e'(rd_addr))
      RA_DESC_A: rd_data = desc_a_q;
      RA_DESC_B: rd_data = desc_b_q;
      RA_INDEX:  rd_data = idx_q;
      default:   rd_data = {{(REG_W-1){1'b0}}, busy_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
      desc_a_q     <= '0;
      desc_b_q     <= '0;
      idx_q        <= '0;
      busy_q       <= 1'b0;
      cmd_q        <= CMD_NOP;
      utlb_inv     <= 1'b0;
      lk_rsp_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_pfn       <= '0;
      lk_perm      <= '0;
    end else begin
      // lookup path sees the table before this edge's command
      lk_rsp_valid <= lk_valid;
      lk_hit       <= lk_valid && (|lk_hitv);
      lk_pfn       <= (lk_valid && (|lk_hitv)) ? lk_ents[lk_first].pfn  : '0;
      lk_perm      <= (lk_valid && (|lk_hitv)) ? lk_ents[lk_first].perm : '0;
      utlb_inv     <= 1'b0;
      if (busy_q) begin
        busy_q <= 1'b0;
        case (cmd_q)
          CMD_WRITE, CMD_WRITE_KEEP: begin
            if (!idx_err) begin
              mem_q[idx_lin] <= desc_unpack(desc_a_q, desc_b_q);
              utlb_inv       <= (cmd_q == CMD_WRITE);
            end
          end
          CMD_READ: begin
            if (!idx_err) begin
              desc_a_q <= desc_a_pack(mem_q[idx_lin]);
              desc_b_q <= desc_b_pack(mem_q[idx_lin]);
            end
          end
          CMD_PROBE: begin
            if ($countones(cmd_hit) > 1)  idx_q <= CODE_DUP;
            else if (|cmd_hit)            idx_q <= REG_W'({cmd_set, cmd_first});
            else                          idx_q <= CODE_MISS;
          end
          CMD_PICK: begin
            idx_q <= REG_W'({cmd_set, vic_way});
            if (vic_use_rr) rr_q[cmd_set] <= rr_q[cmd_set] + WAY_W'(1);
          end
          CMD_UTLB_INV: utlb_inv <= 1'b1;
          default: ;
        endcase
      end else if (cfg_valid) begin
        case (tlb_reg_e'(cfg_addr))
          RA_DESC_A: desc_a_q <= cfg_wdata;
          RA_DESC_B: desc_b_q <= cfg_wdata;
          RA_INDEX:  idx_q    <= cfg_wdata & IDX_KEEP;
          default: begin
            cmd_q  <= tlb_cmd_e'(cfg_wdata[2:0]);
            busy_q <= 1'b1;
          end
        endcase
      end
    end
  end

  // R3: a command holds the port for exactly one cycle
  p_busy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  p_cmd_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready && cfg_addr == 2'd3) |=> busy_q);
  // R6: multiple matching ways give the duplicate code
  p_dup_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cmd_q == CMD_PROBE && $countones(cmd_hit) > 1)
      |=> (idx_q[B_ERR_ANY] && idx_q[B_ERR_DUP]));
  // R10: the invalidate pulse only follows an executed command
  p_inv_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |-> $past(busy_q));
  // R11: a hit is only reported for a request one cycle earlier
  p_hit_has_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> $past(lk_valid));
endmodule

// File: tb/xlat_tlb_tb_top.sv
module xlat_tlb_tb_top;
  localparam int SETS = 128;
  localparam int WAYS = 4;
  localparam int ENT  = SETS * WAYS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        lk_valid = 1'b0;
  logic [18:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_rsp_valid, lk_hit, utlb_inv;
  logic [18:0] lk_pfn;
  logic [5:0]  lk_perm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xlat_tlb #(.SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .lk_perm(lk_perm), .utlb_inv(utlb_inv)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_v[ENT], m_g[ENT], m_asid[ENT], m_vpn[ENT], m_pfn[ENT], m_perm[ENT];
  int m_rr[SETS];
  logic [31:0] m_a, m_b, m_idx;
  bit m_busy, m_utlb, e_lkv, e_lkh;
  int m_cmd, e_pfn, e_perm;

  function automatic bit m_match(int li, int vpn, int asid);
    return m_v[li] != 0 && m_vpn[li] == vpn && (m_g[li] != 0 || m_asid[li] == asid);
  endfunction

  always @(posedge clk) begin
    int s, cnt, first, li, vpn, asid;
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin
        m_v[i] = 0; m_g[i] = 0; m_asid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_perm[i] = 0;
      end
      for (int i = 0; i < SETS; i++) m_rr[i] = 0;
      m_a = 0; m_b = 0; m_idx = 0; m_busy = 0; m_utlb = 0; m_cmd = 0;
      e_lkv = 0; e_lkh = 0; e_pfn = 0; e_perm = 0;
    end else begin
      m_utlb = 0;
      e_lkv = lk_valid; e_lkh = 0; e_pfn = 0; e_perm = 0;
      if (lk_valid) begin
        s = int'(lk_vpn) % SETS;
        for (int w = WAYS - 1; w >= 0; w--)
          if (m_match(s * WAYS + w, int'(lk_vpn), int'(lk_asid))) begin
            e_lkh = 1; e_pfn = m_pfn[s * WAYS + w]; e_perm = m_perm[s * WAYS + w];
          end
      end
      if (m_busy) begin
        m_busy = 0;
        li = int'(m_idx) & (ENT - 1);
        vpn = int'(m_a >> 13); asid = int'(m_a & 32'hFF);
        s = vpn % SETS;
        case (m_cmd)
          1, 2: if (!m_idx[31]) begin
            m_v[li] = int'(m_a[8]); m_g[li] = int'(m_a[9]);
            m_asid[li] = asid; m_vpn[li] = vpn;
            m_pfn[li] = int'(m_b >> 13); m_perm[li] = int'(m_b & 32'h3F);
            if (m_cmd == 1) m_utlb = 1;
          end
          3: if (!m_idx[31]) begin
            m_a = (m_vpn[li] << 13) | (m_g[li] << 9) | (m_v[li] << 8) | m_asid[li];
            m_b = (m_pfn[li] << 13) | m_perm[li];
          end
          4: begin
            cnt = 0; first = 0;
            for (int w = WAYS - 1; w >= 0; w--)
              if (m_match(s * WAYS + w, vpn, asid)) begin cnt++; first = w; end
            if (cnt > 1) m_idx = 32'hC000_0000;
            else if (cnt == 1) m_idx = s * WAYS + first;
            else m_idx = 32'h8000_0000;
          end
          5: begin
            first = -1;
            for (int w = WAYS - 1; w >= 0; w--) if (m_v[s * WAYS + w] == 0) first = w;
            if (first < 0) begin first = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % WAYS; end
            m_idx = s * WAYS + first;
          end
          6: m_utlb = 1;
          default: ;
        endcase
      end else if (cfg_valid) begin
        case (cfg_addr)
          2'd0: m_a = cfg_wdata;
          2'd1: m_b = cfg_wdata;
          2'd2: m_idx = cfg_wdata & (32'hC000_0000 | (ENT - 1));
          default: begin m_cmd = int'(cfg_wdata & 7); m_busy = 1; end
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_a;
      2'd1: return m_b;
      2'd2: return m_idx;
      default: return {31'b0, m_busy};
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "cfg_ready", {31'b0, cfg_ready}, {31'b0, !m_busy});
      chk("R10", "utlb_inv", {31'b0, utlb_inv}, {31'b0, m_utlb});
      chk("R11", "lk_rsp_valid", {31'b0, lk_rsp_valid}, {31'b0, e_lkv});
      chk("R11", "lk_hit", {31'b0, lk_hit}, {31'b0, e_lkh});
      chk("R11", "lk_pfn", {13'b0, lk_pfn}, e_pfn);
      chk("R11", "lk_perm", {26'b0, lk_perm}, e_perm);
      chk("R2", "rd_data", rd_data, exp_rd(rd_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk_a(int vpn, int asid, int v, int g);
    return (vpn << 13) | (g << 9) | (v << 8) | asid;
  endfunction
  function automatic logic [31:0] mk_b(int pfn, int perm);
    return (pfn << 13) | perm;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    cfg_valid = 1'b1; cfg_addr = a; cfg_wdata = d;
    forever begin
      @(negedge clk);
      if (cfg_ready) break;
    end
    @(posedge clk); #2;
    cfg_valid = 1'b0;
  endtask

  // returns just after the edge that executed the command
  task automatic cmd(input int c);
    wr(2'd3, c);
    @(posedge clk); #2;
  endtask

  task automatic peek(input logic [1:0] a, input string req, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, "register read", rd_data, exp);
  endtask

  task automatic put(input int idx, input logic [31:0] a, input logic [31:0] b);
    wr(2'd2, idx); wr(2'd0, a); wr(2'd1, b); cmd(1);
  endtask

  task automatic probe(input logic [31:0] a, input string req, input logic [31:0] exp);
    wr(2'd0, a); cmd(4); peek(2'd2, req, exp);
  endtask

  task automatic pick(input logic [31:0] a, input string req, input logic [31:0] exp);
    wr(2'd0, a); cmd(5); peek(2'd2, req, exp);
  endtask

  task automatic look(input int vpn, input int asid, input string req,
                      input bit h, input int pfn, input int perm);
    @(posedge clk); #2;
    lk_valid = 1'b1; lk_vpn = vpn[18:0]; lk_asid = asid[7:0];
    @(posedge clk); #2;
    lk_valid = 1'b0;
    chk(req, "lookup hit", {31'b0, lk_hit}, {31'b0, h});
    chk(req, "lookup pfn", {13'b0, lk_pfn}, pfn);
    chk(req, "lookup perm", {26'b0, lk_perm}, perm);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    @(posedge clk); #2;
    peek(2'd0, "R1", 32'h0); peek(2'd1, "R1", 32'h0);
    peek(2'd2, "R1", 32'h0); peek(2'd3, "R1", 32'h0);
    chk("R1", "cfg_ready", {31'b0, cfg_ready}, 32'h1);
    probe(mk_a(0, 0, 0, 0), "R1", 32'h8000_0000);

    // R2/R9/R10 write with reserved bits, then read back
    put(22, mk_a(32'h105, 8'h21, 1, 0) | 32'h800, mk_b(32'h3ABCD, 6'h2D) | 32'h40);
    chk("R10", "inv after write", {31'b0, utlb_inv}, 32'h1);
    peek(2'd0, "R2", 32'h0020_A921);
    wr(2'd0, 0); wr(2'd1, 0); cmd(3);
    peek(2'd0, "R2", 32'h0020_A121);
    peek(2'd1, "R9", 32'h7579_A02D);

    // R5/R4/R7 probe hit and ID mismatch
    probe(mk_a(32'h105, 8'h21, 1, 0), "R5", 32'd22);
    probe(mk_a(32'h105, 8'h22, 1, 0), "R7", 32'h8000_0000);

    // R7 global ignores ID
    put(28, mk_a(32'h207, 8'h05, 1, 1), mk_b(32'h11111, 6'h38));
    probe(mk_a(32'h207, 8'h77, 0, 0), "R7", 32'd28);
    look(32'h207, 8'h99, "R7", 1'b1, 32'h11111, 6'h38);

    // R4 last set, and set from low page bits only
    put(509, mk_a(32'h07F, 8'h10, 1, 0), mk_b(5, 1));
    probe(mk_a(32'h07F, 8'h10, 0, 0), "R4", 32'd509);
    probe(mk_a(32'h17F, 8'h10, 0, 0), "R4", 32'h8000_0000);

    // R6/R11 duplicate
    put(23, mk_a(32'h105, 8'h21, 1, 0), mk_b(32'h00042, 6'h07));
    probe(mk_a(32'h105, 8'h21, 1, 0), "R6", 32'hC000_0000);
    look(32'h105, 8'h21, "R11", 1'b1, 32'h3ABCD, 6'h2D);

    // R9 write and read ignored while error flag set
    wr(2'd0, mk_a(32'h080, 8'h01, 1, 0)); wr(2'd1, mk_b(1, 6'h3F)); cmd(1);
    chk("R9", "inv on ignored write", {31'b0, utlb_inv}, 32'h0);
    probe(mk_a(32'h080, 8'h01, 1, 0), "R9", 32'h8000_0000);
    cmd(3);
    peek(2'd0, "R9", mk_a(32'h080, 8'h01, 1, 0));

    // R12 erase
    put(23, 0, 0);
    probe(mk_a(32'h105, 8'h21, 1, 0), "R12", 32'd22);

    // R8 pick slot
    pick(mk_a(32'h209, 0, 0, 0), "R8", 32'd36);
    put(36, mk_a(32'h009, 3, 1, 0), mk_b(32'h100, 1));
    put(37, mk_a(32'h089, 3, 1, 0), mk_b(32'h101, 2));
    put(38, mk_a(32'h109, 3, 1, 0), mk_b(32'h102, 3));
    put(39, mk_a(32'h189, 3, 1, 0), mk_b(32'h103, 4));
    pick(mk_a(32'h209, 0, 0, 0), "R8", 32'd36);
    cmd(5); peek(2'd2, "R8", 32'd37);
    cmd(5); peek(2'd2, "R8", 32'd38);
    put(37, 0, 0);
    pick(mk_a(32'h209, 0, 0, 0), "R8", 32'd37);
    put(37, mk_a(32'h089, 3, 1, 0), mk_b(32'h101, 2));
    pick(mk_a(32'h209, 0, 0, 0), "R8", 32'd39);
    cmd(5); peek(2'd2, "R8", 32'd36);
    pick(mk_a(32'h005, 0, 0, 0), "R8", 32'd20);

    // R10 write-keep and explicit invalidate
    wr(2'd2, 22); wr(2'd0, mk_a(32'h105, 8'h21, 1, 0)); wr(2'd1, mk_b(32'h3ABCD, 6'h2D));
    cmd(2);
    chk("R10", "inv after write-keep", {31'b0, utlb_inv}, 32'h0);
    cmd(6);
    chk("R10", "inv after invalidate", {31'b0, utlb_inv}, 32'h1);

    // R11 miss returns zeros
    look(32'h333, 0, "R11", 1'b0, 0, 0);

    // R3 busy and back-pressure
    wr(2'd3, 7);
    chk("R3", "ready while busy", {31'b0, cfg_ready}, 32'h0);
    peek(2'd3, "R3", 32'h1);
    @(posedge clk); #2;
    peek(2'd3, "R3", 32'h0);
    wr(2'd3, 6);
    wr(2'd0, 32'hDEAD_BEEF);
    peek(2'd0, "R3", 32'hDEAD_BEEF);

    repeat (3) @(posedge clk);
    #2 done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule